// File: doc/BRIEF.md
# Twin-Port RAM with Mailbox Interrupts and Collision Flag

This block is a synchronous memory that two agents, called left and right, can reach at the same time through two fully independent ports on a shared clock. Each port has its own address, write data, byte-lane enables, write strobe and a pair of chip selects of opposite polarity. Reads pass through two register stages. A port that has nothing to read returns zeros, and so does any lane whose byte enable is low.

The two highest words of the array are mailboxes. The top word belongs to the left port and the word just below it belongs to the right port. When one port writes into the other port's mailbox, the owner's active-low interrupt goes low. It comes back high when the owner reads that mailbox. Each interrupt is a two-state machine. In `MB_CLEAR` the interrupt pin is high. The `post` transition moves it to `MB_PENDING`, and it fires when the peer writes the box with at least one byte lane enabled. The `take` transition returns it to `MB_CLEAR`, and it fires when the owner reads the box while no `post` happens in the same cycle.

A collision watcher flags every cycle in which both ports are selected on the same address. That flag travels down a fixed-length delay line and raises `busy` on both ports five clocks later, for one cycle per colliding cycle. Depth, lane count, lane width and the busy delay are all parameters.

Top module: `twinport_mailbox_ram`

## Requirements
- R1: A port is selected only when its `ce_n` is 0 and its `ce` is 1 in the same cycle. A write strobe on a port that is not selected leaves the memory unchanged.
- R2: During a write, byte lane i (bits 8i+7..8i) is updated only when `be[i]` is 1. All other lanes of the word keep their old value.
- R3: A read captured at clock edge k shows its data on `rdata` after edge k+1. Lanes whose `be` bit was 0 at capture read as zero. A cycle with no selected read produces all zeros on `rdata` two edges later.
- R4: Address DEPTH-1 is the left mailbox and DEPTH-2 is the right mailbox. A right-port write to DEPTH-1 with any `be` bit set drives `l_int_n` low after that edge. A left-port write to DEPTH-2 drives `r_int_n` low in the same way. A port writing its own mailbox does not touch its own interrupt.
- R5: A selected read by the owner of its own mailbox returns its interrupt high after that edge. If the peer writes that mailbox in the same cycle, the interrupt stays low.
- R6: A mailbox write with every `be` bit at 0 does not set the interrupt. A mailbox read by a port that is not selected does not clear it. With neither event, the interrupt holds.
- R7: If both ports are selected on equal addresses at edge k, then `l_busy` and `r_busy` are both high exactly during the cycle after edge k+4. Each colliding cycle gives exactly one busy cycle.
- R8: If both ports write the same address in one cycle, the left port's data wins on every lane that both enable. Lanes enabled by only one port take that port's data.
- R9: While reset is asserted and right after it, both interrupts are high, both busy outputs are low and both `rdata` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_be | input | LANES | Left byte-lane enables |
| l_ce_n | input | 1 | Left active-low select |
| l_ce | input | 1 | Left active-high select |
| l_we | input | 1 | Left write strobe (0 = read) |
| l_rdata | output | DATA_W | Left read data, two-stage pipeline |
| l_busy | output | 1 | Left delayed collision flag |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_be | input | LANES | Right byte-lane enables |
| r_ce_n | input | 1 | Right active-low select |
| r_ce | input | 1 | Right active-high select |
| r_we | input | 1 | Right write strobe (0 = read) |
| r_rdata | output | DATA_W | Right read data, two-stage pipeline |
| r_busy | output | 1 | Right delayed collision flag |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
A mailbox machine stuck in the wrong state shows on its interrupt pin at the very next edge after a `post` or `take`, so each transition is checked one cycle after its stimulus. A delay line with the wrong length or a stuck stage moves or removes the busy pulse. That only shows up four to six cycles after the collision, so every edge in that window is sampled. Byte-lane and arbitration faults stay hidden in the array until a later read, and they appear two edges after that read's capture.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic [0:0] {
        MB_CLEAR   = 1'b0,
        MB_PENDING = 1'b1
    } mb_state_t;
endpackage

// File: rtl/tpm_array.sv
// Storage split into one memory per byte lane, with a first read register per port.
module tpm_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [LANES-1:0]  l_be,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_sel,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [LANES-1:0]  r_be,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_q,
    output logic [DATA_W-1:0] r_q
);
    logic l_wr, r_wr, l_rd, r_rd;

    assign l_wr = l_sel & l_we;
    assign r_wr = r_sel & r_we;
    assign l_rd = l_sel & ~l_we;
    assign r_rd = r_sel & ~r_we;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic [BYTE_W-1:0] l_q_lane, r_q_lane;

        // Right write first, left write last: on a same-lane clash the left wins.
        always_ff @(posedge clk) begin
            if (r_wr && r_be[g]) begin
                lane_mem[r_addr] <= r_wdata[g*BYTE_W +: BYTE_W];
            end
            if (l_wr && l_be[g]) begin
                lane_mem[l_addr] <= l_wdata[g*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                l_q_lane <= '0;
                r_q_lane <= '0;
            end else begin
                l_q_lane <= (l_rd && l_be[g]) ? lane_mem[l_addr] : '0;
                r_q_lane <= (r_rd && r_be[g]) ? lane_mem[r_addr] : '0;
            end
        end

        assign l_q[g*BYTE_W +: BYTE_W] = l_q_lane;
        assign r_q[g*BYTE_W +: BYTE_W] = r_q_lane;
    end
endmodule

// File: rtl/tpm_rd_stage.sv
// Second read pipeline register of one port.
module tpm_rd_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tpm_mbox_fsm.sv
// Interrupt state machine for one mailbox word.
module tpm_mbox_fsm
    import tpm_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int LANES        = 4,
    parameter int unsigned BOX_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peer_sel,
    input  logic              peer_we,
    input  logic [LANES-1:0]  peer_be,
    input  logic [ADDR_W-1:0] peer_addr,
    input  logic              own_sel,
    input  logic              own_we,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              int_n
);
    localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(BOX_IDX);

    mb_state_t st_q, st_d;
    logic post, take;

    assign post = peer_sel & peer_we & (|peer_be) & (peer_addr == BOX_A);
    assign take = own_sel & ~own_we & (own_addr == BOX_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MB_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MB_CLEAR:   if (post)          st_d = MB_PENDING;
            MB_PENDING: if (take && !post) st_d = MB_CLEAR;
        endcase
    end

    always_comb begin
        int_n = (st_q != MB_PENDING);
    end
endmodule

// File: rtl/tpm_collide.sv
// Same-address detector followed by a fixed delay line.
module tpm_collide #(
    parameter int ADDR_W = 6,
    parameter int LAT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy
);
    logic           hit;
    logic [LAT-1:0] sr_q;

    assign hit = l_sel & r_sel & (l_addr == r_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[LAT-2:0], hit};
    end

    assign busy = sr_q[LAT-1];
endmodule

// File: rtl/twinport_mailbox_ram.sv
module twinport_mailbox_ram #(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int BYTE_W   = 8,
    parameter int BUSY_LAT = 5,
    localparam int DATA_W  = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [LANES-1:0]  l_be,
    input  logic              l_ce_n,
    input  logic              l_ce,
    input  logic              l_we,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy,
    output logic              l_int_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic [LANES-1:0]  r_be,
    input  logic              r_ce_n,
    input  logic              r_ce,
    input  logic              r_we,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy,
    output logic              r_int_n
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int L_BOX_IDX = DEPTH - 1;
    localparam int R_BOX_IDX = DEPTH - 2;

    logic              l_sel, r_sel, busy;
    logic [DATA_W-1:0] l_q1, r_q1;

    assign l_sel = ~l_ce_n & l_ce;
    assign r_sel = ~r_ce_n & r_ce;

    tpm_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
        .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_be(r_be), .r_wdata(r_wdata),
        .l_q(l_q1), .r_q(r_q1)
    );

    tpm_rd_stage #(.DATA_W(DATA_W)) u_l_rd (.clk(clk), .rst_n(rst_n), .d(l_q1), .q(l_rdata));
    tpm_rd_stage #(.DATA_W(DATA_W)) u_r_rd (.clk(clk), .rst_n(rst_n), .d(r_q1), .q(r_rdata));

    tpm_mbox_fsm #(.ADDR_W(ADDR_W), .LANES(LANES), .BOX_IDX(L_BOX_IDX)) u_l_box (
        .clk(clk), .rst_n(rst_n),
        .peer_sel(r_sel), .peer_we(r_we), .peer_be(r_be), .peer_addr(r_addr),
        .own_sel(l_sel), .own_we(l_we), .own_addr(l_addr),
        .int_n(l_int_n)
    );

    tpm_mbox_fsm #(.ADDR_W(ADDR_W), .LANES(LANES), .BOX_IDX(R_BOX_IDX)) u_r_box (
        .clk(clk), .rst_n(rst_n),
        .peer_sel(l_sel), .peer_we(l_we), .peer_be(l_be), .peer_addr(l_addr),
        .own_sel(r_sel), .own_we(r_we), .own_addr(r_addr),
        .int_n(r_int_n)
    );

    tpm_collide #(.ADDR_W(ADDR_W), .LAT(BUSY_LAT)) u_coll (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .r_sel(r_sel), .l_addr(l_addr), .r_addr(r_addr),
        .busy(busy)
    );

    assign l_busy = busy;
    assign r_busy = busy;
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int DATA_W   = 32,
    parameter int BUSY_LAT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [LANES-1:0]  l_be,
    input logic              l_ce_n,
    input logic              l_ce,
    input logic              l_we,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy,
    input logic              l_int_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [LANES-1:0]  r_be,
    input logic              r_ce_n,
    input logic              r_ce,
    input logic              r_we,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy,
    input logic              r_int_n
);
    localparam logic [ADDR_W-1:0] LBOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] RBOX = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic ls, rs, l_post, r_post, l_take, r_take;
    logic [BUSY_LAT-1:0] seen_q;

    assign ls     = !l_ce_n && l_ce;
    assign rs     = !r_ce_n && r_ce;
    assign l_post = rs && r_we && (r_be != '0) && (r_addr == LBOX);
    assign r_post = ls && l_we && (l_be != '0) && (l_addr == RBOX);
    assign l_take = ls && !l_we && (l_addr == LBOX);
    assign r_take = rs && !r_we && (r_addr == RBOX);

    // Delay window tracked by a local history rather than a deep $past.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= {seen_q[BUSY_LAT-2:0], ls && rs && (l_addr == r_addr)};
    end

    p_busy_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy == seen_q[BUSY_LAT-1]);
    p_busy_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy == r_busy);
    p_lint_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_post |=> !l_int_n);
    p_rint_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_post |=> !r_int_n);
    p_lint_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_take && !l_post) |=> l_int_n);
    p_rint_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_take && !r_post) |=> r_int_n);
    p_lint_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_take && !l_post) |=> $stable(l_int_n));
    p_rint_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_take && !r_post) |=> $stable(r_int_n));
    p_l_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls && !l_we) |-> ##2 (l_rdata == '0));
    p_r_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs && !r_we) |-> ##2 (r_rdata == '0));
endmodule

bind twinport_mailbox_ram tpm_chk #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W), .BUSY_LAT(BUSY_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_be(l_be), .l_ce_n(l_ce_n), .l_ce(l_ce), .l_we(l_we),
    .l_rdata(l_rdata), .l_busy(l_busy), .l_int_n(l_int_n),
    .r_addr(r_addr), .r_be(r_be), .r_ce_n(r_ce_n), .r_ce(r_ce), .r_we(r_we),
    .r_rdata(r_rdata), .r_busy(r_busy), .r_int_n(r_int_n)
);

// File: tb/twinport_mailbox_ram_tb.sv
module twinport_mailbox_ram_tb;
    localparam int AW = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [3:0]    l_be = '0, r_be = '0;
    logic l_ce_n = 1'b1, l_ce = 1'b0, l_we = 1'b0;
    logic r_ce_n = 1'b1, r_ce = 1'b0, r_we = 1'b0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy, l_int_n, r_busy, r_int_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    twinport_mailbox_ram u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_be(l_be), .l_ce_n(l_ce_n), .l_ce(l_ce),
        .l_we(l_we), .l_rdata(l_rdata), .l_busy(l_busy), .l_int_n(l_int_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_be(r_be), .r_ce_n(r_ce_n), .r_ce(r_ce),
        .r_we(r_we), .r_rdata(r_rdata), .r_busy(r_busy), .r_int_n(r_int_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic drv_l(input logic sel, input logic we, input logic [AW-1:0] a,
                         input logic [3:0] be, input logic [DW-1:0] d);
        l_ce_n = !sel; l_ce = sel; l_we = we; l_addr = a; l_be = be; l_wdata = d;
    endtask

    task automatic drv_r(input logic sel, input logic we, input logic [AW-1:0] a,
                         input logic [3:0] be, input logic [DW-1:0] d);
        r_ce_n = !sel; r_ce = sel; r_we = we; r_addr = a; r_be = be; r_wdata = d;
    endtask

    task automatic idle;
        drv_l(1'b0, 1'b0, '0, '0, '0);
        drv_r(1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic wr_l(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
        drv_l(1'b1, 1'b1, a, be, d); step; idle;
    endtask

    task automatic wr_r(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
        drv_r(1'b1, 1'b1, a, be, d); step; idle;
    endtask

    task automatic rd_l(input logic [AW-1:0] a, input logic [3:0] be, output logic [DW-1:0] q);
        drv_l(1'b1, 1'b0, a, be, '0); step; idle; step; q = l_rdata;
    endtask

    task automatic rd_r(input logic [AW-1:0] a, input logic [3:0] be, output logic [DW-1:0] q);
        drv_r(1'b1, 1'b0, a, be, '0); step; idle; step; q = r_rdata;
    endtask

    task automatic t_reset;
        chk("R9 l_int_n", 64'(l_int_n), 64'd1);
        chk("R9 r_int_n", 64'(r_int_n), 64'd1);
        chk("R9 busy", 64'({l_busy, r_busy}), 64'd0);
        chk("R9 rdata", 64'({l_rdata, r_rdata}), 64'd0);
    endtask

    task automatic t_collide;
        logic [DW-1:0] q;
        repeat (6) step;
        drv_l(1'b1, 1'b0, 6'd20, 4'hF, '0);
        drv_r(1'b1, 1'b0, 6'd20, 4'hF, '0);
        step; idle;
        for (int i = 0; i < 6; i++) begin
            chk("R7 l_busy window", 64'(l_busy), 64'(i == 4));
            chk("R7 r_busy window", 64'(r_busy), 64'(i == 4));
            step;
        end
        // Different addresses, then one side deselected: no busy.
        drv_l(1'b1, 1'b0, 6'd20, 4'hF, '0);
        drv_r(1'b1, 1'b0, 6'd21, 4'hF, '0);
        step;
        drv_r(1'b0, 1'b0, 6'd20, 4'hF, '0);
        r_ce_n = 1'b0;
        step; idle;
        for (int i = 0; i < 6; i++) begin
            chk("R7 no busy without match", 64'(l_busy | r_busy), 64'd0);
            step;
        end
        rd_l(6'd20, 4'hF, q);
    endtask

    task automatic t_bytes;
        logic [DW-1:0] q;
        wr_l(6'd5, 4'hF, 32'h1122_3344);
        wr_l(6'd5, 4'b0101, 32'hAABB_CCDD);
        rd_r(6'd5, 4'hF, q);
        chk("R2 partial lane write", 64'(q), 64'h11BB_33DD);
        rd_r(6'd5, 4'b0011, q);
        chk("R3 masked read lanes", 64'(q), 64'h0000_33DD);
        // R1: ce_n high, then ce low: write must not land.
        drv_l(1'b1, 1'b1, 6'd5, 4'hF, 32'hDEAD_BEEF); l_ce_n = 1'b1; step; idle;
        drv_l(1'b1, 1'b1, 6'd5, 4'hF, 32'hDEAD_BEEF); l_ce = 1'b0; step; idle;
        rd_l(6'd5, 4'hF, q);
        chk("R1 deselected write ignored", 64'(q), 64'h11BB_33DD);
    endtask

    task automatic t_latency;
        wr_r(6'd7, 4'hF, 32'hCAFE_0007);
        step; step;
        drv_l(1'b1, 1'b0, 6'd7, 4'hF, '0);
        step; idle;
        chk("R3 data not after first edge", 64'(l_rdata), 64'd0);
        step;
        chk("R3 data after second edge", 64'(l_rdata), 64'hCAFE_0007);
        step;
        chk("R3 zero after idle", 64'(l_rdata), 64'd0);
    endtask

    task automatic t_mailbox;
        logic [DW-1:0] q;
        wr_r(6'd63, 4'h0, 32'h1);
        chk("R6 empty-be write no interrupt", 64'(l_int_n), 64'd1);
        wr_r(6'd63, 4'h1, 32'h0000_005A);
        chk("R4 left int set", 64'(l_int_n), 64'd0);
        chk("R4 right int untouched", 64'(r_int_n), 64'd1);
        wr_r(6'd62, 4'hF, 32'h0);
        chk("R4 own-box write no own int", 64'(r_int_n), 64'd1);
        drv_l(1'b1, 1'b0, 6'd63, 4'hF, '0); l_ce = 1'b0; step; idle;
        chk("R6 deselected read keeps int", 64'(l_int_n), 64'd0);
        drv_l(1'b1, 1'b0, 6'd63, 4'hF, '0); step; idle;
        chk("R5 owner read clears", 64'(l_int_n), 64'd1);
        step;
        chk("R4 mailbox data", 64'(l_rdata[7:0]), 64'h5A);
        wr_l(6'd62, 4'h8, 32'hFF00_0000);
        chk("R4 right int set", 64'(r_int_n), 64'd0);
        drv_r(1'b1, 1'b0, 6'd62, 4'hF, '0);
        drv_l(1'b1, 1'b1, 6'd62, 4'h1, 32'h1);
        step; idle;
        chk("R5 set beats clear", 64'(r_int_n), 64'd0);
        rd_r(6'd62, 4'hF, q);
        chk("R5 right read clears", 64'(r_int_n), 64'd1);
    endtask

    task automatic t_same_write;
        logic [DW-1:0] q;
        wr_l(6'd9, 4'hF, 32'h0);
        drv_l(1'b1, 1'b1, 6'd9, 4'b0011, 32'hAAAA_AAAA);
        drv_r(1'b1, 1'b1, 6'd9, 4'b0110, 32'hBBBB_BBBB);
        step; idle;
        rd_l(6'd9, 4'hF, q);
        chk("R8 left wins shared lane", 64'(q), 64'h00BB_AAAA);
    endtask

    initial begin
        repeat (3) step;
        t_reset;
        rst_n = 1'b1;
        step;
        t_reset;
        t_collide;
        t_bytes;
        t_latency;
        t_mailbox;
        t_same_write;
        repeat (8) step;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule